// File: doc/BRIEF.md
# Registered-IO SRAM with pass-through

This block is a single-clock synchronous static memory with a 9-bit word, separate input and output data buses, and a depth set by parameter. On every rising clock edge it captures the address, the input word and three active-low controls: chip enable, write enable and output enable. One cycle later an output register loads either the word read from the array or the captured input word. The output bus is modelled as a data value plus a drive flag, and the drive flag stands in for the three-state buffer.

The controls behave unusually. The chip enable never deselects the memory. It only decides whether a captured write reaches the array. A write-enabled cycle always forwards its input word to the output, so a write is also transparent and a cycle with the chip enable high is a pure pass-through. The output enable alone decides whether the output is driven. When it is high, the output register keeps its previous word. A synchronous active-low reset leaves the captured controls inactive, so the outputs start undriven.

Top module: `regio_sram`

## Requirements
- R1: While the reset is low, and on the first output cycle after it, dout_en is 0 and dout is 0.
- R2: A cycle with we_n=1 and oe_n=0 at address A drives the stored word of A on dout, with dout_en=1, after the second rising edge that follows its inputs.
- R3: A cycle with ce_n=0, we_n=0 and oe_n=0 writes din to address A and also shows din on dout with dout_en=1 at the same output time as R2.
- R4: A cycle with ce_n=1, we_n=0 and oe_n=0 shows din on dout with dout_en=1 and leaves the array unchanged, which a later read shows.
- R5: dout_en in each output cycle equals the inverse of the oe_n captured one cycle earlier, whatever ce_n and we_n were.
- R6: A cycle with ce_n=0, we_n=0 and oe_n=1 still writes the array, while dout_en is 0 and dout is unchanged.
- R7: A read of an address that was written in the immediately preceding cycle returns the newly written word.
- R8: A read with ce_n=1 works the same as a read with ce_n=0, because the chip enable does not deselect the memory.
- R9: In every output cycle whose captured oe_n was 1, dout keeps the value it had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Every input is captured on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | Word address |
| din | input | DATA_W | Input data word |
| ce_n | input | 1 | Chip enable, active low. It gates array writes only. |
| we_n | input | 1 | Write enable, active low. It selects pass-through of din. |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Output register value |
| dout_en | output | 1 | Output drive flag. When it is 0 the bus is high-impedance. |

## Verification
The assertions check four things on every cycle, each against the captured controls of two edges earlier: that the drive flag follows the output enable alone, that a write-enabled cycle forwards din, that an undriven cycle holds dout, and that a read directly after a write to the same address returns the new word. Other behaviours show only in the bench's scenarios, where a behavioural model keeps its own copy of memory and follows the reads over many cycles. These include the stored contents that a pass-through must leave untouched, a write that completes while the outputs float, and a read taken with the chip enable high.

// File: rtl/regio_sram_pkg.sv
package regio_sram_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  // array write: chip enable and write enable both active
  function automatic logic is_write(ctl_t c);
    return !c.ce_n && !c.we_n;
  endfunction

  // output mux picks captured input data whenever write enable was active
  function automatic logic is_pass(ctl_t c);
    return !c.we_n;
  endfunction

  function automatic logic is_drive(ctl_t c);
    return !c.oe_n;
  endfunction

endpackage

// File: rtl/regio_sram_capture.sv
module regio_sram_capture
  import regio_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] din,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  output logic [AW-1:0] a_q,
  output logic [DW-1:0] d_q,
  output ctl_t          c_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      d_q <= '0;
      c_q <= CTL_IDLE;
    end else begin
      a_q <= addr_in;
      d_q <= din;
      c_q <= '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};
    end
  end

endmodule

// File: rtl/regio_sram_array.sv
module regio_sram_array #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  // the read sees the word as it was before this edge's write
  assign rdata = mem[addr];

endmodule

// File: rtl/regio_sram_outreg.sv
module regio_sram_outreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive,
  input  logic          pass_sel,
  input  logic [DW-1:0] pass_data,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  logic [DW-1:0] mux_out;

  assign mux_out = pass_sel ? pass_data : array_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= drive;
      if (drive) dout <= mux_out;
    end
  end

endmodule

// File: rtl/regio_sram.sv
module regio_sram
  import regio_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [DATA_W-1:0] rdata;
  ctl_t              c_q;

  // named events for the checker
  logic wr_fire;
  logic pass_sel;
  logic drive_next;
  logic rd_fire;

  assign wr_fire    = is_write(c_q);
  assign pass_sel   = is_pass(c_q);
  assign drive_next = is_drive(c_q);
  assign rd_fire    = drive_next && !pass_sel;

  regio_sram_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .din(din),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .a_q(a_q), .d_q(d_q), .c_q(c_q)
  );

  regio_sram_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk(clk), .wr(wr_fire), .addr(a_q), .wdata(d_q), .rdata(rdata)
  );

  regio_sram_outreg #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .drive(drive_next), .pass_sel(pass_sel),
    .pass_data(d_q), .array_data(rdata), .dout(dout), .dout_en(dout_en)
  );

endmodule

// File: rtl/regio_sram_chk.sv
module regio_sram_chk #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] din,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic [AW-1:0] a_q,
  input logic [DW-1:0] d_q,
  input logic          wr_fire,
  input logic          rd_fire
);

  logic [1:0]    cyc;
  logic          warm;
  logic          prev_wr;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc       <= 2'd0;
      prev_wr   <= 1'b0;
      prev_addr <= '0;
      prev_data <= '0;
    end else begin
      if (cyc != 2'd2) cyc <= cyc + 2'd1;
      prev_wr   <= wr_fire;
      prev_addr <= a_q;
      prev_data <= d_q;
    end
  end

  assign warm = (cyc == 2'd2);

  p_drive_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(oe_n, 2)) |-> dout_en);

  p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(oe_n, 2)) |-> !dout_en);

  p_pass_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(oe_n, 2) && !$past(we_n, 2)) |-> (dout == $past(din, 2)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(oe_n, 2)) |-> $stable(dout));

  p_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && prev_wr && (a_q == prev_addr)) |=> (dout == $past(prev_data)));

endmodule

bind regio_sram regio_sram_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .we_n(we_n), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en), .a_q(a_q), .d_q(d_q),
  .wr_fire(wr_fire), .rd_fire(rd_fire)
);

// File: tb/regio_sram_bench.sv
`timescale 1ns/1ps
module regio_sram_bench;

  localparam int AW = 6;
  localparam int DW = 9;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] din = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #2.5 clk = ~clk;

  regio_sram #(.ADDR_W(AW), .DATA_W(DW)) u_regio_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .din(din),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  int vectors = 0;
  int errors  = 0;
  int model_mem [N];
  int model_out = 0;
  int exp_d [$];
  int exp_e [$];
  string exp_tag [$];

  task automatic check(string tag, int act_d, int act_e, int e_d, int e_e);
    vectors++;
    if (act_d != e_d || act_e != e_e) begin
      errors++;
      $display("FAIL %s: dout=%0h en=%0d expected dout=%0h en=%0d",
               tag, act_d, act_e, e_d, e_e);
    end
  endtask

  // one cycle: compare the result of the stimulus from two cycles ago, then drive
  task automatic step(bit c, bit w, bit g, int a, int d, string tag);
    int ed, ee;
    @(negedge clk);
    if (exp_d.size() == 2) begin
      ed = exp_d.pop_front();
      ee = exp_e.pop_front();
      check(exp_tag.pop_front(), int'(dout), int'(dout_en), ed, ee);
    end
    ce_n = c; we_n = w; oe_n = g;
    addr_in = AW'(a); din = DW'(d);
    if (!w) begin
      if (!c) model_mem[a] = d;
      if (!g) model_out = d;
    end else if (!g) begin
      model_out = model_mem[a];
    end
    exp_d.push_back(model_out);
    exp_e.push_back(g ? 0 : 1);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 0, 0, "R9 idle hold");
  endtask

  bit done = 1'b0;

  initial begin
    #200000;
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(dout), int'(dout_en), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset release", int'(dout), int'(dout_en), 0, 0);

    // R3: transparent writes fill every address
    for (int i = 0; i < N; i++) step(0, 0, 0, i, (i * 37 + 5) & 9'h1ff, "R3 transparent write");
    // R2: reads in a spread order
    for (int i = 0; i < N; i++) step(0, 1, 0, (i * 13) % N, 0, "R2 read");
    // R4: pass-through with chip enable high, then read back the unchanged words
    for (int i = 0; i < 8; i++) step(1, 0, 0, i, 9'h0a5 ^ i, "R4 pass-through");
    for (int i = 0; i < 8; i++) step(0, 1, 0, i, 0, "R4 array unchanged");
    // R6: write with outputs floating, then reads
    step(0, 1, 0, 20, 0, "R2 read before float");
    for (int i = 20; i < 26; i++) step(0, 0, 1, i, 9'h100 + i, "R6 write floating");
    for (int i = 20; i < 26; i++) step(0, 1, 0, i, 0, "R6 readback");
    // R7: back-to-back write then read of the same address
    for (int i = 30; i < 38; i++) begin
      step(0, 0, 1, i, 9'h155 ^ (i * 3), "R7 write");
      step(0, 1, 0, i, 0, "R7 read after write");
    end
    step(0, 0, 0, 40, 9'h1ff, "R3 write all ones");
    step(0, 1, 0, 40, 0, "R7 read after transparent write");
    // R8: reads with chip enable high
    for (int i = 0; i < 10; i++) step(1, 1, 0, i * 5, 0, "R8 read ce high");
    // R5: drive flag follows only oe_n across control mixes
    for (int i = 0; i < 16; i++)
      step(bit'(i & 1), bit'((i >> 1) & 1), bit'((i >> 2) & 1), 50 + (i & 7), 9'h033 + i, "R5 control mix");
    // R9: hold while undriven
    step(0, 1, 0, 3, 0, "R2 read before hold");
    step(1, 0, 1, 4, 9'h1c3, "R9 float pass ignored");
    idle(4);
    step(0, 1, 0, 4, 0, "R4 read after floating pass");
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule